// File: doc/BRIEF.md
# Serial Port Interrupt Source Identifier

This block sits beside the receive path, transmit path and modem-control logic of a FIFO-capable serial port. It holds one pending flag for each of five interrupt causes: receive line error, received data available, receive character timeout, transmit holding empty and modem status change. It drives a single interrupt request line and an 8-bit identification byte that the host reads to find the most urgent cause.

Each flag is set by a one-cycle strobe from the surrounding logic. Each flag is cleared only by the register access that services it. An enable nibble gates which flags may raise the request and appear in the identification byte. A flag whose enable is off still stays pending.

While the identification read strobe is high, the byte is held. Events recorded during the read therefore cannot change what the host sees.

Top module: `uart_irq_ident`

## Requirements
- R1: Among the enabled pending causes, the low nibble of `id_out` reports the most urgent one, in this order: line error `0110`, then received data `0100`, then character timeout `1100`, then transmit holding empty `0010`, then modem status `0000`. Enable bits are `ier[0]` for received data and timeout, `ier[1]` for transmit holding empty, `ier[2]` for line error and `ier[3]` for modem status.
- R2: Bit 0 of `id_out` is active low. With nothing enabled and pending, the low nibble is `0001`.
- R3: Bit 3 is 1 only for the timeout code. While `fifo_en` is 0, `rx_timeout` is ignored and any pending timeout is dropped, so bit 3 stays 0.
- R4: `id_out[5:4]` are always 0. `id_out[7:6]` both equal `fifo_en`.
- R5: While `id_rd` is high, `id_out` does not change, even if new causes are recorded during that time.
- R6: The line error flag is set by `line_err` and cleared by `lsr_rd`.
- R7: The received data flag is set by `rx_avail_set` and cleared by `rbr_rd` or by `rx_below_trig`.
- R8: The timeout flag is set by `rx_timeout` (FIFO mode only) and cleared by `rbr_rd`. `rx_below_trig` does not clear it.
- R9: The transmit holding empty flag is set by `thr_empty_set`. It is cleared by `thr_wr`, or in the cycle `id_rd` falls if the held byte reported code `0010`.
- R10: The modem status flag is set by `modem_chg` and cleared by `msr_rd`.
- R11: `irq` is high whenever any enabled flag is pending. A disabled pending flag stays pending and raises `irq` as soon as its enable is set.
- R12: When a set strobe and a clear access for the same flag arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier | input | 4 | Per-cause enable nibble |
| fifo_en | input | 1 | FIFO mode enable |
| line_err | input | 1 | Overrun, parity, framing or break detected |
| rx_avail_set | input | 1 | Received data available event |
| rx_timeout | input | 1 | Receive character timeout event |
| thr_empty_set | input | 1 | Transmit holding register became empty |
| modem_chg | input | 1 | Modem status input changed |
| rx_below_trig | input | 1 | Receive FIFO level below trigger |
| id_rd | input | 1 | Identification register read in progress |
| lsr_rd | input | 1 | Line status register read |
| rbr_rd | input | 1 | Receive buffer read |
| thr_wr | input | 1 | Transmit holding register write |
| msr_rd | input | 1 | Modem status register read |
| id_out | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
A flag changes at the first clock edge after its strobe. From that flag, `irq` follows with no further register, so `irq` is due one edge after the strobe. `id_out` is registered, so it is due two edges after the strobe.

The bench drives inputs on the falling edge. It checks `irq` one falling edge after a strobe and `id_out` one falling edge later. For the freeze and read-clear cases, it counts the edges from the fall of `id_rd` the same way.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ier,
  input  logic       fifo_en,
  input  logic       line_err,
  input  logic       rx_avail_set,
  input  logic       rx_timeout,
  input  logic       thr_empty_set,
  input  logic       modem_chg,
  input  logic       rx_below_trig,
  input  logic       id_rd,
  input  logic       lsr_rd,
  input  logic       rbr_rd,
  input  logic       thr_wr,
  input  logic       msr_rd,
  output logic [7:0] id_out,
  output logic       irq
);
  localparam logic [3:0] C_NONE = 4'b0001;
  localparam logic [3:0] C_LS   = 4'b0110;
  localparam logic [3:0] C_RDA  = 4'b0100;
  localparam logic [3:0] C_TO   = 4'b1100;
  localparam logic [3:0] C_THRE = 4'b0010;
  localparam logic [3:0] C_MS   = 4'b0000;

  logic ls_q, rda_q, to_q, thre_q, ms_q, rd_q;
  logic [7:0] id_q;
  logic [3:0] code;

  wire e_ls   = ls_q   & ier[2];
  wire e_rda  = rda_q  & ier[0];
  wire e_to   = to_q   & ier[0];
  wire e_thre = thre_q & ier[1];
  wire e_ms   = ms_q   & ier[3];
  wire rd_hit = rd_q & ~id_rd & (id_q[3:0] == C_THRE);

  always_comb begin
    if      (e_ls)   code = C_LS;
    else if (e_rda)  code = C_RDA;
    else if (e_to)   code = C_TO;
    else if (e_thre) code = C_THRE;
    else if (e_ms)   code = C_MS;
    else             code = C_NONE;
  end

  wire [7:0] live = {{2{fifo_en}}, 2'b00, code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q <= 1'b0; rda_q <= 1'b0; to_q <= 1'b0; thre_q <= 1'b0; ms_q <= 1'b0;
      rd_q <= 1'b0;
      id_q <= {4'h0, C_NONE};
    end else begin
      ls_q   <= line_err | (ls_q & ~lsr_rd);
      rda_q  <= rx_avail_set | (rda_q & ~rbr_rd & ~rx_below_trig);
      to_q   <= fifo_en & (rx_timeout | (to_q & ~rbr_rd));
      thre_q <= thr_empty_set | (thre_q & ~thr_wr & ~rd_hit);
      ms_q   <= modem_chg | (ms_q & ~msr_rd);
      rd_q   <= id_rd;
      if (!id_rd) id_q <= live;
    end
  end

  assign id_out = id_q;
  assign irq    = e_ls | e_rda | e_to | e_thre | e_ms;

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd && $past(id_rd) |-> $stable(id_out));
  p_zero_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    id_out[5:4] == 2'b00);
  p_pend_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(id_rd) |-> id_out[0] == !$past(irq));
  p_ls_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !line_err |=> !ls_q);
  p_ms_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msr_rd && !modem_chg |=> !ms_q);
  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |=> ls_q);
  p_no_to_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !to_q);
endmodule

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ier = 4'h0;
  logic fifo_en = 1'b0, line_err = 1'b0, rx_avail_set = 1'b0, rx_timeout = 1'b0;
  logic thr_empty_set = 1'b0, modem_chg = 1'b0, rx_below_trig = 1'b0, id_rd = 1'b0;
  logic lsr_rd = 1'b0, rbr_rd = 1'b0, thr_wr = 1'b0, msr_rd = 1'b0;
  logic [7:0] id_out;
  logic irq;
  int nvec = 0, nbad = 0;

  always #2 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic clr_all;
    {lsr_rd, rbr_rd, thr_wr, msr_rd} = 4'hF; tick; {lsr_rd, rbr_rd, thr_wr, msr_rd} = 4'h0;
  endtask

  task automatic set_src(input logic [4:0] s);
    {modem_chg, thr_empty_set, rx_timeout, rx_avail_set, line_err} = s; tick;
    {modem_chg, thr_empty_set, rx_timeout, rx_avail_set, line_err} = 5'b0;
  endtask

  function automatic logic [7:0] exp_id(input logic [4:0] s, input logic [3:0] e, input logic fe);
    logic [3:0] c;
    if      (s[0] & e[2])      c = 4'b0110;
    else if (s[1] & e[0])      c = 4'b0100;
    else if (s[2] & fe & e[0]) c = 4'b1100;
    else if (s[3] & e[1])      c = 4'b0010;
    else if (s[4] & e[3])      c = 4'b0000;
    else                       c = 4'b0001;
    return {{2{fe}}, 2'b00, c};
  endfunction

  initial begin
    #(4.0 * 200000);
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    tick; tick; rst_n = 1'b1; tick;
    chk(id_out, 8'h01, "R2 reset id");
    chk({7'b0, irq}, 8'h00, "R11 reset irq");

    // R1 R2 R3 R4 R11 sweep
    for (int fe = 0; fe < 2; fe++)
      for (int e = 0; e < 16; e++)
        for (int s = 0; s < 32; s++) begin
          fifo_en = fe[0]; ier = e[3:0];
          clr_all;
          set_src(s[4:0]);
          chk({7'b0, irq}, {7'b0, exp_id(s[4:0], e[3:0], fe[0])[0] == 1'b0}, "R11 irq sweep");
          tick;
          chk(id_out, exp_id(s[4:0], e[3:0], fe[0]), "R1 R3 R4 id sweep");
        end

    // R5 freeze, R9 clear by read
    fifo_en = 1'b1; ier = 4'hF; clr_all;
    set_src(5'b01000); tick;
    id_rd = 1'b1; tick;
    chk(id_out, 8'hC2, "R5 read start");
    set_src(5'b00001); tick; tick;
    chk(id_out, 8'hC2, "R5 frozen during read");
    id_rd = 1'b0; tick;
    chk(id_out, 8'hC6, "R5 released shows line error");
    lsr_rd = 1'b1; tick; lsr_rd = 1'b0; tick;
    chk(id_out, 8'hC1, "R9 thre cleared by id read, R6 ls cleared");

    // R9 thr_wr clear
    clr_all; set_src(5'b01000); tick;
    chk(id_out, 8'hC2, "R9 thre set");
    thr_wr = 1'b1; tick; thr_wr = 1'b0; tick;
    chk(id_out, 8'hC1, "R9 thre cleared by write");

    // R10 modem clear
    set_src(5'b10000); tick;
    chk(id_out, 8'hC0, "R10 ms set");
    msr_rd = 1'b1; tick; msr_rd = 1'b0; tick;
    chk(id_out, 8'hC1, "R10 ms cleared");

    // R7 R8 below-trigger clears data, not timeout
    set_src(5'b00110); tick;
    chk(id_out, 8'hC4, "R7 rda over timeout");
    rx_below_trig = 1'b1; tick; rx_below_trig = 1'b0; tick;
    chk(id_out, 8'hCC, "R8 timeout kept after below-trigger");
    rbr_rd = 1'b1; tick; rbr_rd = 1'b0; tick;
    chk(id_out, 8'hC1, "R8 timeout cleared by rbr read");
    set_src(5'b00010); tick;
    rbr_rd = 1'b1; tick; rbr_rd = 1'b0; tick;
    chk(id_out, 8'hC1, "R7 rda cleared by rbr read");

    // R3 timeout dropped when FIFO disabled
    set_src(5'b00100); tick;
    chk(id_out, 8'hCC, "R3 timeout in fifo mode");
    fifo_en = 1'b0; tick; tick;
    chk(id_out, 8'h01, "R3 timeout dropped non-fifo");

    // R12 set wins
    line_err = 1'b1; lsr_rd = 1'b1; tick; line_err = 1'b0; lsr_rd = 1'b0; tick;
    chk(id_out, 8'h06, "R12 set beats clear");
    lsr_rd = 1'b1; tick; lsr_rd = 1'b0;

    // R11 disabled source stays pending
    ier = 4'h0; clr_all; set_src(5'b10000); tick;
    chk({7'b0, irq}, 8'h00, "R11 disabled no irq");
    chk(id_out, 8'h01, "R11 disabled not reported");
    ier = 4'h8; #0;
    chk({7'b0, irq}, 8'h01, "R11 enable raises irq");
    tick;
    chk(id_out, 8'h00, "R11 enabled reports modem");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule